// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small processor core that fetches, decodes and retires one instruction on every rising clock edge. It supports a fixed 32-bit encoding with ten instructions: five register-to-register operations (add, subtract, and, or, signed set-less-than), an or with an immediate, a word load, a word store, branch-if-equal and an absolute jump. Inside the core are the program counter, a 32-entry by 32-bit register file with two read ports and one write port, the immediate extender, the ALU, and the multiplexers that pick the write-back value and the next PC.

Instruction memory and data memory sit outside the core. Both are read combinationally: the core presents an address and uses the returned word in the same cycle. The data memory is written on the shared clock edge while the core asserts its write strobe. Each memory answers within the cycle, so there is no stall and no valid/ready handshake on these ports. Every instruction completes in exactly one clock.

Top module: `scp_core`

## Requirements
- R1: A synchronous active-high reset sets the PC, shown on `imem_addr`, to 0 and clears registers 1 to 31. No data memory write happens while reset is asserted.
- R2: Field layout is op[31:26], rs[25:21], rt[20:16], rd[15:11], funct[5:0], imm[15:0], target[25:0]. With op 000000, funct 100000 writes rs+rt to rd, 100010 writes rs-rt, 100100 writes rs AND rt, and 100101 writes rs OR rt.
- R3: With op 000000 and funct 101010, rd receives 1 when rs is less than rt as signed values, and 0 otherwise.
- R4: op 001101 writes rs OR the zero-extended imm into rt.
- R5: op 100011 writes into rt the data memory word at rs plus the sign-extended imm. op 101011 writes rt to that same address. A negative imm lowers the address.
- R6: Only op 101011 drives the data memory write strobe. Store and branch instructions write no register.
- R7: op 000100 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended imm shifted left by 2. Otherwise the next PC is PC+4.
- R8: op 000010 sets the PC to {PC+4[31:28], target, 2'b00}.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Every instruction other than a taken branch or a jump advances the PC by 4 on the next clock edge, one instruction per cycle. The PC stays word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word returned combinationally |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data memory write strobe, applied at the next rising edge |
| dmem_rdata | input | 32 | Load data returned combinationally |

## Verification
Several properties are checked on every cycle: the PC update rules for sequential flow, taken branches and jumps, word alignment of the PC, the rule that a store never writes a register, the zero value read from register 0, the single-bit result of set-less-than, and the PC value after reset. Arithmetic results, the path from load data to write-back, zero versus sign extension of immediates, and discarded writes to register 0 show up only in the memory contents that a program leaves behind. The bench therefore runs a fixed program over a sweep of operand pairs (signed extremes, equal values, mixed signs) and compares each stored word with a value it computes itself.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned NREG   = 32;
  localparam int unsigned RIDX_W = $clog2(NREG);

  localparam logic [5:0] OPC_REG  = 6'b000000;
  localparam logic [5:0] OPC_ORI  = 6'b001101;
  localparam logic [5:0] OPC_LOAD = 6'b100011;
  localparam logic [5:0] OPC_STOR = 6'b101011;
  localparam logic [5:0] OPC_BEQ  = 6'b000100;
  localparam logic [5:0] OPC_JMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_fn_e;

  typedef struct packed {
    logic    dst_is_rd;   // write index from rd (else rt)
    logic    b_is_imm;    // ALU B from immediate (else rt)
    logic    wb_from_mem; // write-back from load data
    logic    reg_we;
    logic    mem_we;
    logic    imm_signed;  // sign-extend immediate (else zero)
    logic    branch_eq;
    logic    jump;
    alu_fn_e alu_fn;
  } ctrl_t;
endpackage

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  alu_fn_e reg_fn;

  always_comb begin
    unique case (funct)
      FN_SUB:  reg_fn = ALU_SUB;
      FN_AND:  reg_fn = ALU_AND;
      FN_OR:   reg_fn = ALU_OR;
      FN_SLT:  reg_fn = ALU_SLT;
      default: reg_fn = ALU_ADD;
    endcase
  end

  always_comb begin
    ctrl = '{dst_is_rd: 1'b0, b_is_imm: 1'b0, wb_from_mem: 1'b0, reg_we: 1'b0,
             mem_we: 1'b0, imm_signed: 1'b1, branch_eq: 1'b0, jump: 1'b0,
             alu_fn: ALU_ADD};
    case (opcode)
      OPC_REG: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_we    = 1'b1;
        ctrl.alu_fn    = reg_fn;
      end
      OPC_ORI: begin
        ctrl.b_is_imm   = 1'b1;
        ctrl.reg_we     = 1'b1;
        ctrl.imm_signed = 1'b0;
        ctrl.alu_fn     = ALU_OR;
      end
      OPC_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.reg_we      = 1'b1;
        ctrl.wb_from_mem = 1'b1;
      end
      OPC_STOR: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch_eq = 1'b1;
        ctrl.alu_fn    = ALU_SUB;
      end
      OPC_JMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         is_zero
);
  logic [W-1:0] diff;
  logic         lt_signed;

  assign diff      = a - b;
  assign lt_signed = (a[W-1] != b[W-1]) ? a[W-1] : diff[W-1];

  always_comb begin
    unique case (fn)
      ALU_SUB: y = diff;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, lt_signed};
      default: y = a + b;
    endcase
  end

  assign is_zero = (y == '0);
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int unsigned W    = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [NREG*W-1:0] flat;

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign flat[0 +: W] = '0;
    end else begin : g_store
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (we && waddr == AW'(i)) q <= wdata;
      end
      assign flat[i*W +: W] = q;
    end
  end

  assign rdata_a = flat[raddr_a*W +: W];
  assign rdata_b = flat[raddr_b*W +: W];
endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam int unsigned W  = XLEN;
  localparam int unsigned AW = RIDX_W;

  logic [W-1:0]  pc_q, pc_next, pc_seq, pc_br, pc_jmp;
  logic [AW-1:0] f_rs, f_rt, f_rd, wr_idx;
  logic [15:0]   f_imm;
  logic [W-1:0]  imm_ext, src_a, src_b, alu_b, alu_y, wb_val;
  logic          alu_zero, rf_we, take_br;
  ctrl_t         ctl;

  assign f_rs  = imem_data[25:21];
  assign f_rt  = imem_data[20:16];
  assign f_rd  = imem_data[15:11];
  assign f_imm = imem_data[15:0];

  scp_decode u_dec (
    .opcode (imem_data[31:26]),
    .funct  (imem_data[5:0]),
    .ctrl   (ctl)
  );

  assign imm_ext = ctl.imm_signed ? {{(W-16){f_imm[15]}}, f_imm} : {{(W-16){1'b0}}, f_imm};
  assign wr_idx  = ctl.dst_is_rd ? f_rd : f_rt;
  assign rf_we   = ctl.reg_we & ~rst;
  assign wb_val  = ctl.wb_from_mem ? dmem_rdata : alu_y;

  scp_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (wr_idx),
    .wdata   (wb_val),
    .raddr_a (f_rs),
    .raddr_b (f_rt),
    .rdata_a (src_a),
    .rdata_b (src_b)
  );

  assign alu_b = ctl.b_is_imm ? imm_ext : src_b;

  scp_alu #(.W(W)) u_alu (
    .a       (src_a),
    .b       (alu_b),
    .fn      (ctl.alu_fn),
    .y       (alu_y),
    .is_zero (alu_zero)
  );

  assign dmem_addr  = alu_y;
  assign dmem_wdata = src_b;
  assign dmem_we    = ctl.mem_we & ~rst;

  assign pc_seq  = pc_q + W'(4);
  assign pc_br   = pc_seq + {imm_ext[W-3:0], 2'b00};
  assign pc_jmp  = {pc_seq[31:28], imem_data[25:0], 2'b00};
  assign take_br = ctl.branch_eq & alu_zero;

  always_comb begin
    if (ctl.jump)     pc_next = pc_jmp;
    else if (take_br) pc_next = pc_br;
    else              pc_next = pc_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  assign imem_addr = pc_q;

  AST_RESET_PC: assert property (@(posedge clk) $past(rst) |-> imem_addr == RESET_PC); // R1
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ctl.jump && !take_br) |=> imem_addr == $past(imem_addr) + 32'd4); // R10
  AST_PC_ALIGN: assert property (@(posedge clk) disable iff (rst) imem_addr[1:0] == 2'b00); // R10
  AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (ctl.branch_eq && src_a == src_b) |=>
      imem_addr == $past(imem_addr) + 32'd4 + {$past(imm_ext[29:0]), 2'b00}); // R7
  AST_JUMP_DEST: assert property (@(posedge clk) disable iff (rst)
    ctl.jump |=> imem_addr == {$past(pc_seq[31:28]), $past(imem_data[25:0]), 2'b00}); // R8
  AST_STORE_NO_REGWR: assert property (@(posedge clk) disable iff (rst) dmem_we |-> !rf_we); // R6
  AST_BEQ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ctl.branch_eq |-> (!rf_we && !dmem_we)); // R6
  AST_SLT_ONEBIT: assert property (@(posedge clk) disable iff (rst)
    (ctl.alu_fn == ALU_SLT) |-> alu_y[W-1:1] == '0); // R3
  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (f_rs == '0) |-> src_a == '0); // R9
endmodule

// File: tb/sim_scp_core.sv
module sim_scp_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  int          checks = 0;
  int          failures = 0;

  logic [31:0] im [64];
  logic [31:0] dm [64];
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  always #5 clk = ~clk;

  assign imem_data  = im[imem_addr[7:2]];
  assign dmem_rdata = dm[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dm[dmem_addr[7:2]] <= dmem_wdata;

  scp_core u0 (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'b00000, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [25:0] t);
    return {6'b000010, t};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_program();
    for (int i = 0; i < 64; i++) im[i] = enc_j(26'd26);
    im[0]  = enc_i(6'b100011, 5'd0, 5'd1, 16'd0);      // lw r1,0(r0)
    im[1]  = enc_i(6'b100011, 5'd0, 5'd2, 16'd4);      // lw r2,4(r0)
    im[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'b100000);       // add
    im[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'b100010);       // sub
    im[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'b100100);       // and
    im[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'b100101);       // or
    im[6]  = enc_r(5'd1, 5'd2, 5'd7, 6'b101010);       // slt
    im[7]  = enc_i(6'b001101, 5'd1, 5'd8, 16'h8001);   // ori
    for (int k = 0; k < 6; k++)
      im[8+k] = enc_i(6'b101011, 5'd0, 5'(3+k), 16'(8+4*k)); // sw r3..r8 -> words 2..7
    im[14] = enc_i(6'b000100, 5'd1, 5'd2, 16'd2);      // beq -> word 17
    im[15] = enc_i(6'b001101, 5'd0, 5'd9, 16'h1111);
    im[16] = enc_j(26'd18);
    im[17] = enc_i(6'b001101, 5'd0, 5'd9, 16'h2222);
    im[18] = enc_i(6'b101011, 5'd0, 5'd12, 16'd52);    // r12 after reset -> word 13
    im[19] = enc_r(5'd1, 5'd2, 5'd0, 6'b100000);       // write to r0
    im[20] = enc_i(6'b101011, 5'd0, 5'd0, 16'd32);     // -> word 8
    im[21] = enc_i(6'b101011, 5'd0, 5'd9, 16'd36);     // -> word 9
    im[22] = enc_i(6'b001101, 5'd0, 5'd11, 16'd48);
    im[23] = enc_i(6'b101011, 5'd11, 5'd2, 16'hFFFC);  // -> word 11
    im[24] = enc_i(6'b100011, 5'd11, 5'd12, 16'hFFFC);
    im[25] = enc_i(6'b101011, 5'd0, 5'd12, 16'd48);    // -> word 12
    im[26] = enc_j(26'd26);                            // halt loop
  endtask

  task automatic run_pair(input logic [31:0] a, input logic [31:0] b, input bit first);
    rst = 1'b1;
    for (int i = 0; i < 64; i++) dm[i] = SENT;
    dm[0] = a;
    dm[1] = b;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 pc in reset", imem_addr, 32'd0);
    rst = 1'b0;
    chk("R1 pc after reset", imem_addr, 32'd0);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (first) chk("R10 sequential pc", imem_addr, 32'(4*k));
    end
    repeat (34) @(negedge clk);
    chk("R2 add", dm[2], a + b);
    chk("R2 sub", dm[3], a - b);
    chk("R2 and", dm[4], a & b);
    chk("R2 or",  dm[5], a | b);
    chk("R3 slt", dm[6], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
    chk("R4 ori zero-extend", dm[7], a | 32'h0000_8001);
    chk("R9 r0 write ignored", dm[8], 32'd0);
    chk("R7 beq path", dm[9], (a == b) ? 32'h2222 : 32'h1111);
    chk("R6 untouched word", dm[10], SENT);
    chk("R5 sw negative offset", dm[11], b);
    chk("R5 lw write-back", dm[12], b);
    chk("R1 register cleared", dm[13], 32'd0);
    chk("R8 jump self loop", imem_addr, 32'd104);
  endtask

  initial begin
    logic [31:0] va [11];
    logic [31:0] vb [11];
    va = '{32'd5, 32'd3, 32'd7, 32'hFFFF_FFFF, 32'd1, 32'h8000_0000, 32'h7FFF_FFFF,
           32'd0, 32'hA5A5_A5A5, 32'h1234_5678, 32'hFFFF_0000};
    vb = '{32'd3, 32'd5, 32'd7, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
           32'd0, 32'h5A5A_5A5A, 32'h1234_5678, 32'h0000_FFFF};
    load_program();
    for (int p = 0; p < 11; p++) run_pair(va[p], vb[p], p == 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule